// File: doc/BRIEF.md
# DDR2 Bank Activate Timing Checker

This block sits beside a DDR2 command bus and watches it. It does not drive the bus. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable lines into one of four commands: activate, read, write or precharge. The command goes to one of four banks. For each bank the checker tracks whether a row is open and which row it is. Each bank also has three timers: activate-to-column delay, activate-to-precharge time and precharge-to-activate time.

A command that breaks the bank protocol or a timing window is reported one cycle later on a registered error interface. The report carries a 3-bit code, the bank and a row. The column delay is checked together with the programmed additive latency. A read or write issued early is still legal when the latency pushes the internal command late enough. The checker follows the bus even when a command is flagged, so one bad command does not cause a cascade of false reports.

Top module: `ddr2_act_timing_chk`

## Requirements
- R1: Commands are decoded at the rising edge with chip-select low from {row, column, write} strobes. Activate is 011, read is 101, write is 100 and precharge is 010. Chip-select high, or any other strobe pattern, changes no bank state and gives no error.
- R2: The 2-bit bank input selects one of four banks. The state and timers of each bank are separate from those of every other bank.
- R3: A read or write to a bank with no open row reports code 1.
- R4: A read or write issued d cycles after the activate of its bank (d at least 1) is legal when d plus the effective additive latency is at least the programmed column delay. Otherwise it reports code 3.
- R5: The effective additive latency is the programmed value when that value is 0 to 4. Programmed values 5 to 7 act as 4.
- R6: An activate to a bank that is already open reports code 2. This code wins over code 5. The bank stays open with the new row, and its column-delay and activate-to-precharge timers restart.
- R7: A precharge to an open bank issued fewer than the programmed activate-to-precharge cycles after its activate reports code 4. The bank closes anyway.
- R8: An activate to a closed bank issued fewer than the programmed precharge-to-activate cycles after its precharge reports code 5. The bank opens anyway.
- R9: A precharge to a closed bank is a no-op. It gives no error and does not restart the precharge-to-activate timer.
- R10: A report appears one cycle after the command edge. `err_valid` is 1, `err_code` is 1 to 5, and `err_bank` gives the bank. With no error, `err_valid` is 0 and `err_code` is 0. For an activate, `err_row` is the incoming row. For any other command it is the row last opened in that bank (0 since reset).
- R11: With `wide_row` at 1 the row uses address bits 13:0. With `wide_row` at 0 it uses bits 12:0 and bit 13 is taken as 0.
- R12: While synchronous reset is high, every bank closes, every timer clears and all error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 14 | Row address |
| wide_row | input | 1 | 1: 14-bit row (x4/x8), 0: 13-bit row (x16) |
| cfg_trcd | input | CNT_W | Activate-to-column delay in cycles |
| cfg_tras | input | CNT_W | Activate-to-precharge minimum in cycles |
| cfg_trp | input | CNT_W | Precharge-to-activate minimum in cycles |
| cfg_al | input | 3 | Programmed additive latency |
| err_valid | output | 1 | A violation was seen one cycle earlier |
| err_code | output | 3 | Violation code (0 none, 1 to 5) |
| err_bank | output | 2 | Bank of the reported command |
| err_row | output | 14 | Row tied to the reported command |

## Verification
The assertions check the protocol rules on every cycle:
- an idle or unknown pattern never raises an error;
- a read or write to a closed bank always gives code 1;
- an activate to an open bank always gives code 2;
- activate and precharge always leave the bank in the right open or closed state;
- the code and valid outputs always agree.

The timer boundaries need counting across many cycles, so only the bench scenarios show them: the tRCD window with additive latency and its clamp, the tRAS window, the tRP window, and that a precharge to a closed bank does not restart tRP. The same holds for row masking and the reported row.

// File: rtl/ddr2_chk_pkg.sv
`timescale 1ns/1ps
package ddr2_chk_pkg;

    localparam int BANKS    = 4;
    localparam int BA_W     = $clog2(BANKS);
    localparam int ROW_W    = 14;
    localparam int AL_W     = 3;
    localparam int AL_LIMIT = 4;
    localparam int CODE_W   = 3;

    typedef enum logic [2:0] {
        K_IDLE = 3'd0,
        K_ACT  = 3'd1,
        K_RD   = 3'd2,
        K_WR   = 3'd3,
        K_PRE  = 3'd4
    } cmd_e;

    typedef enum logic [CODE_W-1:0] {
        E_NONE    = 3'd0,
        E_NO_ACT  = 3'd1,
        E_DBL_ACT = 3'd2,
        E_RCD     = 3'd3,
        E_RAS     = 3'd4,
        E_RP      = 3'd5
    } err_e;

    typedef struct packed {
        cmd_e             kind;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
    } bus_cmd_t;

    typedef struct packed {
        err_e             code;
        logic [ROW_W-1:0] row;
    } bank_err_t;

    // Strobe pattern {ras_n, cas_n, we_n} qualified by chip select.
    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e k;
        if (cs_n) begin
            k = K_IDLE;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  k = K_ACT;
                3'b101:  k = K_RD;
                3'b100:  k = K_WR;
                3'b010:  k = K_PRE;
                default: k = K_IDLE;
            endcase
        end
        return k;
    endfunction

    function automatic logic [ROW_W-1:0] mask_row(input logic [ROW_W-1:0] row,
                                                  input logic wide);
        return wide ? row : {1'b0, row[ROW_W-2:0]};
    endfunction

    function automatic logic [AL_W-1:0] clamp_al(input logic [AL_W-1:0] al);
        return (al > AL_W'(AL_LIMIT)) ? AL_W'(AL_LIMIT) : al;
    endfunction

endpackage

// File: rtl/ddr2_cmd_decode.sv
`timescale 1ns/1ps
module ddr2_cmd_decode
    import ddr2_chk_pkg::*;
(
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BA_W-1:0]       ba,
    input  logic [ROW_W-1:0]      addr,
    input  logic                  wide_row,
    output bus_cmd_t              cmd_o
);

    always_comb begin
        cmd_o.kind = decode_pins(cs_n, ras_n, cas_n, we_n);
        cmd_o.bank = ba;
        cmd_o.row  = mask_row(addr, wide_row);
    end

endmodule

// File: rtl/ddr2_bank_track.sv
`timescale 1ns/1ps
module ddr2_bank_track
    import ddr2_chk_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int BANK_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] trcd_i,
    input  logic [CNT_W-1:0] tras_i,
    input  logic [CNT_W-1:0] trp_i,
    input  logic [AL_W-1:0]  al_eff_i,
    output bank_err_t        err_o,
    output logic             open_o
);

    localparam logic [BA_W-1:0] MY_BANK = BA_W'(BANK_ID);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] rcd_q;
    logic [CNT_W-1:0] ras_q;
    logic [CNT_W-1:0] rp_q;
    logic             hit;
    logic [CNT_W-1:0] al_wide;

    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign hit     = (cmd_i.bank == MY_BANK) && (cmd_i.kind != K_IDLE);
    assign al_wide = CNT_W'(al_eff_i);
    assign open_o  = open_q;

    // Timers hold "cycles still missing" as seen at the next command edge.
    always_comb begin
        err_o.code = E_NONE;
        err_o.row  = row_q;
        if (hit) begin
            unique case (cmd_i.kind)
                K_ACT: begin
                    err_o.row = cmd_i.row;
                    if (open_q)
                        err_o.code = E_DBL_ACT;
                    else if (rp_q != '0)
                        err_o.code = E_RP;
                end
                K_RD, K_WR: begin
                    if (!open_q)
                        err_o.code = E_NO_ACT;
                    else if (rcd_q > al_wide)
                        err_o.code = E_RCD;
                end
                K_PRE: begin
                    if (open_q && ras_q != '0)
                        err_o.code = E_RAS;
                end
                default: err_o.code = E_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            ras_q  <= '0;
            rp_q   <= '0;
        end else begin
            rcd_q <= step_down(rcd_q);
            ras_q <= step_down(ras_q);
            rp_q  <= step_down(rp_q);
            if (hit && cmd_i.kind == K_ACT) begin
                open_q <= 1'b1;
                row_q  <= cmd_i.row;
                rcd_q  <= step_down(trcd_i);
                ras_q  <= step_down(tras_i);
            end else if (hit && cmd_i.kind == K_PRE && open_q) begin
                open_q <= 1'b0;
                rp_q   <= step_down(trp_i);
            end
        end
    end

endmodule

// File: rtl/ddr2_err_merge.sv
`timescale 1ns/1ps
module ddr2_err_merge
    import ddr2_chk_pkg::*;
#(
    parameter int N = BANKS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bank_err_t [N-1:0]     errs_i,
    output logic                  err_valid,
    output logic [CODE_W-1:0]     err_code,
    output logic [BA_W-1:0]       err_bank,
    output logic [ROW_W-1:0]      err_row
);

    err_e             sel_code;
    logic [BA_W-1:0]  sel_bank;
    logic [ROW_W-1:0] sel_row;

    // At most one bank is addressed per cycle, so at most one entry is set.
    always_comb begin
        sel_code = E_NONE;
        sel_bank = '0;
        sel_row  = '0;
        for (int b = 0; b < N; b++) begin
            if (errs_i[b].code != E_NONE) begin
                sel_code = errs_i[b].code;
                sel_bank = BA_W'(b);
                sel_row  = errs_i[b].row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= '0;
            err_bank  <= '0;
            err_row   <= '0;
        end else begin
            err_valid <= (sel_code != E_NONE);
            err_code  <= sel_code;
            err_bank  <= sel_bank;
            err_row   <= sel_row;
        end
    end

endmodule

// File: rtl/ddr2_act_timing_chk.sv
`timescale 1ns/1ps
module ddr2_act_timing_chk
    import ddr2_chk_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [1:0]         ba,
    input  logic [13:0]        addr,
    input  logic               wide_row,
    input  logic [CNT_W-1:0]   cfg_trcd,
    input  logic [CNT_W-1:0]   cfg_tras,
    input  logic [CNT_W-1:0]   cfg_trp,
    input  logic [2:0]         cfg_al,
    output logic               err_valid,
    output logic [2:0]         err_code,
    output logic [1:0]         err_bank,
    output logic [13:0]        err_row
);

    bus_cmd_t               cmd;
    logic [AL_W-1:0]        al_eff;
    bank_err_t [BANKS-1:0]  bank_err;
    logic [BANKS-1:0]       bank_open;

    assign al_eff = clamp_al(cfg_al);

    ddr2_cmd_decode u_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr),
        .wide_row (wide_row),
        .cmd_o    (cmd)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        ddr2_bank_track #(
            .CNT_W   (CNT_W),
            .BANK_ID (g)
        ) u_track (
            .clk      (clk),
            .rst      (rst),
            .cmd_i    (cmd),
            .trcd_i   (cfg_trcd),
            .tras_i   (cfg_tras),
            .trp_i    (cfg_trp),
            .al_eff_i (al_eff),
            .err_o    (bank_err[g]),
            .open_o   (bank_open[g])
        );
    end

    ddr2_err_merge #(.N(BANKS)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .errs_i    (bank_err),
        .err_valid (err_valid),
        .err_code  (err_code),
        .err_bank  (err_bank),
        .err_row   (err_row)
    );

endmodule

// File: rtl/ddr2_act_timing_props.sv
`timescale 1ns/1ps
module ddr2_act_timing_props
    import ddr2_chk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic        err_valid,
    input logic [2:0]  err_code,
    input logic [3:0]  bank_open
);

    cmd_e seen;
    always_comb seen = decode_pins(cs_n, ras_n, cas_n, we_n);

    a_r10_code_range: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code >= 3'd1 && err_code <= 3'd5));

    a_r10_quiet_zero: assert property (@(posedge clk) disable iff (rst)
        !err_valid |-> err_code == 3'd0);

    a_r1_idle_silent: assert property (@(posedge clk) disable iff (rst)
        seen == K_IDLE |=> !err_valid);

    a_r3_closed_access: assert property (@(posedge clk) disable iff (rst)
        ((seen == K_RD || seen == K_WR) && !bank_open[ba]) |=> (err_valid && err_code == 3'd1));

    a_r6_double_act: assert property (@(posedge clk) disable iff (rst)
        (seen == K_ACT && bank_open[ba]) |=> (err_valid && err_code == 3'd2));

    a_r7_pre_closes: assert property (@(posedge clk) disable iff (rst)
        seen == K_PRE |=> !bank_open[$past(ba)]);

    a_r8_act_opens: assert property (@(posedge clk) disable iff (rst)
        seen == K_ACT |=> bank_open[$past(ba)]);

endmodule

bind ddr2_act_timing_chk ddr2_act_timing_props u_props (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .err_valid (err_valid),
    .err_code  (err_code),
    .bank_open (bank_open)
);

// File: tb/ddr2_act_timing_chk_tb_top.sv
`timescale 1ns/1ps
module ddr2_act_timing_chk_tb_top;

    localparam int CW = 6;
    localparam int OP_IDLE = 0, OP_ACT = 1, OP_RD = 2, OP_WR = 3, OP_PRE = 4, OP_REF = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]    ba = '0;
    logic [13:0]   addr = '0;
    logic          wide_row = 1'b1;
    logic [CW-1:0] cfg_trcd = '0, cfg_tras = '0, cfg_trp = '0;
    logic [2:0]    cfg_al = '0;
    logic          err_valid;
    logic [2:0]    err_code;
    logic [1:0]    err_bank;
    logic [13:0]   err_row;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ddr2_act_timing_chk #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .wide_row(wide_row), .cfg_trcd(cfg_trcd),
        .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_al(cfg_al),
        .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank), .err_row(err_row)
    );

    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one command for one edge; outputs for it are valid at the next negedge.
    task automatic issue(input int op, input logic [1:0] b, input logic [13:0] r);
        ba = b; addr = r;
        case (op)
            OP_ACT:  {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            OP_RD:   {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            OP_WR:   {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            OP_PRE:  {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            OP_REF:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic idle(input int n);
        cs_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_err(input string req, input int code, input int bank);
        checks++;
        if (err_valid !== (code != 0) || err_code !== 3'(code) ||
            (code != 0 && err_bank !== 2'(bank))) begin
            errors++;
            $display("FAIL %s: valid=%0b code=%0d bank=%0d expected code=%0d bank=%0d",
                     req, err_valid, err_code, err_bank, code, bank);
        end
    endtask

    task automatic expect_row(input string req, input logic [13:0] row);
        checks++;
        if (err_row !== row) begin
            errors++;
            $display("FAIL %s: row=%h expected %h", req, err_row, row);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R12 reset state
        do_reset();
        checks++;
        if (err_valid !== 1'b0 || err_code !== 3'd0 || err_bank !== 2'd0 || err_row !== 14'd0) begin
            errors++;
            $display("FAIL R12: outputs %b %0d %0d %h expected all zero", err_valid, err_code, err_bank, err_row);
        end

        // R3 access to closed banks
        issue(OP_RD, 2'd2, 14'd0); expect_err("R3 rd closed", 1, 2);
        issue(OP_WR, 2'd3, 14'd0); expect_err("R3 wr closed", 1, 3);

        // R1 idle and unknown patterns change nothing
        cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; ba = 2'd1;
        @(negedge clk); expect_err("R1 deselected act", 0, 0);
        issue(OP_REF, 2'd1, 14'd0); expect_err("R1 other pattern", 0, 0);
        issue(OP_RD, 2'd1, 14'd0); expect_err("R1 bank still closed", 1, 1);

        // R4/R5 column delay sweep with additive latency, tRCD = 6
        for (int al = 0; al < 8; al++) begin
            for (int d = 1; d <= 7; d++) begin
                int eff;
                int exp_code;
                cfg_trcd = 6'd6; cfg_al = 3'(al); cfg_tras = 6'd1; cfg_trp = 6'd1;
                do_reset();
                issue(OP_ACT, 2'd1, 14'h123);
                idle(d - 1);
                issue((d % 2 == 0) ? OP_RD : OP_WR, 2'd1, 14'd0);
                eff = (al > 4) ? 4 : al;
                exp_code = (d + eff < 6) ? 3 : 0;
                expect_err((al > 4) ? "R5 clamped latency" : "R4 column delay", exp_code, 1);
            end
        end

        // R7 activate-to-precharge sweep, tRAS = 5
        for (int d = 1; d <= 7; d++) begin
            cfg_trcd = 6'd1; cfg_al = 3'd0; cfg_tras = 6'd5; cfg_trp = 6'd1;
            do_reset();
            issue(OP_ACT, 2'd0, 14'h5);
            idle(d - 1);
            issue(OP_PRE, 2'd0, 14'd0);
            expect_err("R7 tRAS window", (d < 5) ? 4 : 0, 0);
            issue(OP_RD, 2'd0, 14'd0);
            expect_err("R7 bank closed after pre", 1, 0);
        end

        // R8 precharge-to-activate sweep, tRP = 4
        for (int d = 1; d <= 6; d++) begin
            cfg_trcd = 6'd1; cfg_al = 3'd0; cfg_tras = 6'd2; cfg_trp = 6'd4;
            do_reset();
            issue(OP_ACT, 2'd3, 14'h7);
            idle(3);
            issue(OP_PRE, 2'd3, 14'd0);
            expect_err("R8 legal pre", 0, 0);
            idle(d - 1);
            issue(OP_ACT, 2'd3, 14'h8);
            expect_err("R8 tRP window", (d < 4) ? 5 : 0, 3);
            issue(OP_ACT, 2'd3, 14'h9);
            expect_err("R8 bank opened anyway", 2, 3);
        end

        // R6 double activate restarts timers and row; R10 row reporting
        cfg_trcd = 6'd4; cfg_al = 3'd0; cfg_tras = 6'd1; cfg_trp = 6'd1; wide_row = 1'b1;
        do_reset();
        issue(OP_ACT, 2'd2, 14'h0AA);
        idle(6);
        issue(OP_ACT, 2'd2, 14'h0BB);
        expect_err("R6 double activate", 2, 2);
        expect_row("R10 activate row", 14'h0BB);
        issue(OP_RD, 2'd2, 14'd0);
        expect_err("R6 timer restarted", 3, 2);
        expect_row("R10 open row", 14'h0BB);

        // R2 banks independent
        do_reset();
        issue(OP_ACT, 2'd0, 14'h1);
        idle(5);
        issue(OP_RD, 2'd1, 14'd0); expect_err("R2 other bank closed", 1, 1);
        issue(OP_RD, 2'd0, 14'd0); expect_err("R2 own bank open", 0, 0);
        issue(OP_ACT, 2'd1, 14'h2); expect_err("R2 activate second bank", 0, 0);

        // R9 precharge to closed bank does not restart tRP
        cfg_trcd = 6'd1; cfg_tras = 6'd1; cfg_trp = 6'd5;
        do_reset();
        issue(OP_ACT, 2'd1, 14'h3);
        issue(OP_PRE, 2'd1, 14'd0); expect_err("R9 first pre", 0, 0);
        idle(5);
        issue(OP_PRE, 2'd1, 14'd0); expect_err("R9 pre on closed bank", 0, 0);
        issue(OP_ACT, 2'd1, 14'h4); expect_err("R9 tRP not restarted", 0, 0);

        // R11 row width
        for (int w = 0; w < 2; w++) begin
            wide_row = w[0];
            do_reset();
            issue(OP_ACT, 2'd0, 14'h3FFF);
            issue(OP_ACT, 2'd0, 14'h2ABC);
            expect_err("R11 double act", 2, 0);
            expect_row("R11 row mask", w ? 14'h2ABC : 14'h0ABC);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule